// File: doc/BRIEF.md
# Four-Mode Bidirectional Shift Register

This block is a parallel-in, parallel-out register whose next value is picked on every rising clock edge by a two-bit mode code. The four modes are hold, parallel load, logical shift toward the least significant bit, and logical shift toward the most significant bit. Both shifts bring in a zero at the vacated end. Every bit of the stored word is visible on the output at all times.

A mode-enable input gates the selection. While it is low the register keeps its value, whatever the mode code says. A synchronous active-high reset clears the word to zero and overrides every other input. The register width is a parameter, with a default of 8 bits. The design uses one flat register and one next-state multiplexer per bit.

Top module: `bds_shift_reg`

## Requirements
- R1: When `rst` is high at a rising edge, `q` is all zeros after that edge, whatever `mode_en`, `mode` and `d` are.
- R2: With `mode_en` high and `mode` = 2'b11, `q` keeps its value across the edge.
- R3: With `mode_en` high and `mode` = 2'b00, `q` takes the value of `d` at the edge, all bits at once.
- R4: With `mode_en` high and `mode` = 2'b10, each bit of `q` takes its next-higher bit and the MSB becomes 0. For example, 00001110 becomes 00000111, then 00000011, then 00000001, then 00000000.
- R5: With `mode_en` high and `mode` = 2'b01, each bit of `q` takes its next-lower bit and the LSB becomes 0. For example, 00001110 becomes 00011100, then 00111000.
- R6: With `mode_en` low, `q` keeps its value across the edge for every `mode` code and every `d`.
- R7: A shift mode acts again on every edge for as long as it stays selected. After WIDTH consecutive shifts in one direction, `q` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| mode_en | input | 1 | Enables the mode multiplexer; low means hold |
| mode | input | 2 | 11 hold, 00 load, 10 shift right, 01 shift left |
| d | input | WIDTH | Parallel load data |
| q | output | WIDTH | Parallel register contents |

## Verification
The output is the state register itself, so any wrong next-state choice shows on `q` one edge after the stimulus that caused it. A wrong fill bit or a swapped neighbour shows on the first shift. It is then carried along on every later shift, so it shows most clearly on the zero-fill steps at the end of a shift run. A hold or enable fault shows as a change on `q` across an edge where none is allowed. The bench therefore compares `q` after every single edge rather than only at the end of a sequence.

// File: rtl/bds_pkg.sv
package bds_pkg;

  typedef enum logic [1:0] {
    MODE_LOAD = 2'b00,
    MODE_SHL  = 2'b01,
    MODE_SHR  = 2'b10,
    MODE_HOLD = 2'b11
  } shift_mode_e;

endpackage

// File: rtl/bds_next_state.sv
module bds_next_state
  import bds_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              en,
  input  shift_mode_e       mode,
  input  logic [WIDTH-1:0]  cur,
  input  logic [WIDTH-1:0]  load_val,
  output logic [WIDTH-1:0]  nxt
);

  localparam int MSB = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_hi;
    logic from_lo;

    if (i == MSB) begin : g_top
      assign from_hi = 1'b0;
    end else begin : g_mid_hi
      assign from_hi = cur[i+1];
    end

    if (i == 0) begin : g_bot
      assign from_lo = 1'b0;
    end else begin : g_mid_lo
      assign from_lo = cur[i-1];
    end

    always_comb begin
      if (!en) begin
        nxt[i] = cur[i];
      end else begin
        unique case (mode)
          MODE_LOAD: nxt[i] = load_val[i];
          MODE_SHL:  nxt[i] = from_lo;
          MODE_SHR:  nxt[i] = from_hi;
          default:   nxt[i] = cur[i];
        endcase
      end
    end
  end

endmodule

// File: rtl/bds_state_reg.sv
module bds_state_reg #(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  nxt,
  output logic [WIDTH-1:0]  q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R1: clear wins over everything
  p_clear_r1: assert property (@(posedge clk) rst |=> (q == '0))
    else $error("clear did not zero register");

endmodule

// File: rtl/bds_shift_reg.sv
module bds_shift_reg
  import bds_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_en,
  input  logic [1:0]        mode,
  input  logic [WIDTH-1:0]  d,
  output logic [WIDTH-1:0]  q
);

  logic [WIDTH-1:0] nxt_w;
  shift_mode_e      mode_e;

  assign mode_e = shift_mode_e'(mode);

  bds_next_state #(.WIDTH(WIDTH)) u_next (
    .en       (mode_en),
    .mode     (mode_e),
    .cur      (q),
    .load_val (d),
    .nxt      (nxt_w)
  );

  bds_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (nxt_w),
    .q   (q)
  );

  // R2
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_en && mode == 2'b11) |=> $stable(q))
    else $error("hold changed q");

  // R3
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_en && mode == 2'b00) |=> (q == $past(d)))
    else $error("load mismatch");

  // R4
  p_shr_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_en && mode == 2'b10) |=> (q == ($past(q) >> 1)))
    else $error("right shift mismatch");

  // R5
  p_shl_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_en && mode == 2'b01) |=> (q == ($past(q) << 1)))
    else $error("left shift mismatch");

  // R6
  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !mode_en |=> $stable(q))
    else $error("disabled mux changed q");

endmodule

// File: tb/tb_bds_shift_reg.sv
module tb_bds_shift_reg;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         mode_en;
  logic [1:0]   mode;
  logic [W-1:0] d;
  logic [W-1:0] q;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  bds_shift_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .mode_en(mode_en), .mode(mode), .d(d), .q(q)
  );

  task automatic step(input logic r, input logic en, input logic [1:0] m,
                      input logic [W-1:0] din);
    @(negedge clk);
    rst = r; mode_en = en; mode = m; d = din;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [W-1:0] exp, input string req);
    n_cmp++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%b expected=%b", req, q, exp);
    end
  endtask

  task automatic t_reset;
    step(1'b1, 1'b0, 2'b11, 8'hFF);
    check(8'h00, "R1 reset state");
  endtask

  task automatic t_load;
    step(1'b0, 1'b1, 2'b00, 8'hA5);
    check(8'hA5, "R3 load A5");
    step(1'b0, 1'b1, 2'b00, 8'h3C);
    check(8'h3C, "R3 load 3C");
  endtask

  task automatic t_hold;
    step(1'b0, 1'b1, 2'b00, 8'h96);
    step(1'b0, 1'b1, 2'b11, 8'h00);
    check(8'h96, "R2 hold 1");
    step(1'b0, 1'b1, 2'b11, 8'hFF);
    check(8'h96, "R2 hold 2");
  endtask

  task automatic t_shift_right;
    logic [W-1:0] exp;
    step(1'b0, 1'b1, 2'b00, 8'b0000_1110);
    exp = 8'b0000_1110;
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b1, 2'b10, 8'hFF);
      exp = {1'b0, exp[W-1:1]};
      check(exp, "R4 shift right");
    end
    check(8'h00, "R4 example ends at zero");
  endtask

  task automatic t_shift_left;
    logic [W-1:0] exp;
    step(1'b0, 1'b1, 2'b00, 8'b0000_1110);
    exp = 8'b0000_1110;
    for (int k = 0; k < W; k++) begin
      step(1'b0, 1'b1, 2'b01, 8'hFF);
      exp = {exp[W-2:0], 1'b0};
      check(exp, "R5 shift left");
    end
    check(8'h00, "R7 empty after W left shifts");
  endtask

  task automatic t_full_right;
    step(1'b0, 1'b1, 2'b00, 8'hFF);
    for (int k = 0; k < W; k++) step(1'b0, 1'b1, 2'b10, 8'h00);
    check(8'h00, "R7 empty after W right shifts");
  endtask

  task automatic t_enable_off;
    step(1'b0, 1'b1, 2'b00, 8'h5A);
    for (int m = 0; m < 4; m++) begin
      step(1'b0, 1'b0, m[1:0], 8'hC3);
      check(8'h5A, "R6 disabled hold");
    end
  endtask

  task automatic t_reset_priority;
    step(1'b0, 1'b1, 2'b00, 8'hE7);
    step(1'b1, 1'b1, 2'b00, 8'hFF);
    check(8'h00, "R1 reset over load");
    step(1'b0, 1'b1, 2'b00, 8'h81);
    step(1'b1, 1'b0, 2'b11, 8'h00);
    check(8'h00, "R1 reset over disable");
  endtask

  initial begin
    rst = 1'b1; mode_en = 1'b0; mode = 2'b11; d = '0;
    t_reset();
    t_load();
    t_hold();
    t_shift_right();
    t_shift_left();
    t_full_right();
    t_enable_off();
    t_reset_priority();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: q=%b expected=finish", q);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule